// File: doc/BRIEF.md
# Two-Stream Interleave Address Generator

This block steers a row of parallel lanes that together merge two source streams, called A and B, into a single ordered result. On each access every lane presents one select bit: a lane whose bit is 1 takes its next element from stream A, and a lane whose bit is 0 takes it from stream B. The block tells each lane which stream to use and the element position to fetch within that stream. It keeps the two running stream positions so that back-to-back accesses consume each stream contiguously. It produces indices only. The element storage and the crossbar that moves data to the lanes sit outside it.

A lane's position within its stream is the stream base plus the number of lower-numbered lanes that chose the same stream. The A-count comes from a prefix count of the select bits. The B-count is the lane number minus that A-count. After each access the A base moves forward by the number of lanes that chose A, and the B base moves forward by the remaining lanes. A start pulse puts both bases back to zero. The lengths of the two streams are given alongside each access, so every lane is also told when its index lies beyond the end of its stream.

Top module: `ilv_addr_gen`

## Requirements
- R1: While reset is high and on the first cycle after it, `out_valid` is 0. The first access after reset uses base 0 for both streams.
- R2: A lane i with select 1 reports `lane_src[i]`=1. Its index is the A base plus the count of lanes j<i whose select is 1.
- R3: A lane i with select 0 reports `lane_src[i]`=0. Its index is the B base plus i minus the count of lanes j<i whose select is 1.
- R4: `out_num_a` equals the number of select bits that are 1 in the access. It equals the count for the top lane plus that lane's own select.
- R5: After an access, the A base grows by the A total and the B base grows by LANES minus that total.
- R6: A start pulse clears both bases to zero. If a request arrives in the same cycle as start, it is served from base 0, and the bases then advance from zero.
- R7: `lane_past_end[i]` is 1 exactly when the lane's index is greater than or equal to the length of its chosen stream, using `len_a`/`len_b` sampled with the request.
- R8: Results appear one clock after the request. In a cycle with no request, `out_valid` is 0 on the next cycle and neither base moves.
- R9: When all select bits are 1, or all are 0, the lanes read LANES consecutive indices of that one stream in lane order, and the other base does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clears both stream bases to zero |
| req | input | 1 | Access strobe; `sel`, `len_a` and `len_b` are valid |
| sel | input | LANES | Per-lane select, 1 = stream A, 0 = stream B |
| len_a | input | IDX_W | Element count of stream A |
| len_b | input | IDX_W | Element count of stream B |
| out_valid | output | 1 | Per-lane results are valid |
| lane_src | output | LANES | Per-lane chosen stream, 1 = A |
| lane_idx | output | LANES*IDX_W | Per-lane index, lane i in bits [i*IDX_W +: IDX_W] |
| lane_past_end | output | LANES | Per-lane index is at or past the end of its stream |
| out_num_a | output | $clog2(LANES+1) | Number of lanes that took from A |

## Verification
Every result of an access is registered once, so `lane_src`, `lane_idx`, `lane_past_end` and `out_num_a` are due one rising edge after the cycle that carries `req`. The new bases show up in the indices of the next access. The bench drives each request on a falling edge and reads the outputs on the following falling edge, which is one rising edge later. It then drops `req` and keeps a model of the two bases, advanced from the select bits it applied. Idle and start cases are checked through the indices of the access that follows them.

// File: rtl/ilv_pkg.sv
package ilv_pkg;

    typedef enum logic {
        SRC_B = 1'b0,
        SRC_A = 1'b1
    } src_e;

    // Width of a count that can hold the values 0..n
    function automatic int cnt_width(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/ilv_prefix.sv
module ilv_prefix #(
    parameter int LANES = 8,
    parameter int CNT_W = 4
) (
    input  logic [LANES-1:0]       sel,
    output logic [LANES*CNT_W-1:0] acnt,
    output logic [CNT_W-1:0]       num_a
);

    for (genvar i = 0; i < LANES; i++) begin : g_cnt
        logic [CNT_W-1:0] below;
        always_comb begin
            below = '0;
            for (int k = 0; k < i; k++) begin
                below = below + CNT_W'(sel[k]);
            end
        end
        assign acnt[i*CNT_W +: CNT_W] = below;
    end

    // total taken from A: top lane's count plus its own select bit
    assign num_a = acnt[(LANES-1)*CNT_W +: CNT_W] + CNT_W'(sel[LANES-1]);

endmodule

// File: rtl/ilv_lane.sv
module ilv_lane #(
    parameter int IDX_W   = 12,
    parameter int CNT_W   = 4,
    parameter int LANE_ID = 0,
    localparam int PTR_W  = IDX_W + 1
) (
    input  logic             sel_bit,
    input  logic [CNT_W-1:0] acnt,
    input  logic [PTR_W-1:0] base_a,
    input  logic [PTR_W-1:0] base_b,
    input  logic [IDX_W-1:0] len_a,
    input  logic [IDX_W-1:0] len_b,
    output ilv_pkg::src_e    src,
    output logic [IDX_W-1:0] idx,
    output logic             past_end
);
    import ilv_pkg::*;

    logic [CNT_W-1:0] bcnt;
    logic [PTR_W-1:0] full_idx;
    logic [PTR_W-1:0] limit;

    assign bcnt = CNT_W'(LANE_ID) - acnt;

    always_comb begin
        if (sel_bit) begin
            src      = SRC_A;
            full_idx = base_a + PTR_W'(acnt);
            limit    = {1'b0, len_a};
        end else begin
            src      = SRC_B;
            full_idx = base_b + PTR_W'(bcnt);
            limit    = {1'b0, len_b};
        end
    end

    assign idx      = full_idx[IDX_W-1:0];
    assign past_end = (full_idx >= limit);

    // R3: the B count never exceeds the lane number
    always_comb begin
        a_r3_bcnt_bound: assert (bcnt <= CNT_W'(LANE_ID))
            else $error("lane %0d: B count out of range", LANE_ID);
    end

endmodule

// File: rtl/ilv_ptr.sv
module ilv_ptr #(
    parameter int LANES  = 8,
    parameter int PTR_W  = 13,
    parameter int CNT_W  = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             req,
    input  logic [CNT_W-1:0] num_a,
    output logic [PTR_W-1:0] base_a,
    output logic [PTR_W-1:0] base_b
);

    localparam logic [CNT_W-1:0] LANES_C = CNT_W'(LANES);

    logic [PTR_W-1:0] ptr_a, ptr_b;
    logic [PTR_W-1:0] step_a, step_b;
    logic             seen;

    // a start pulse makes a same-cycle access use base zero
    assign base_a = start ? '0 : ptr_a;
    assign base_b = start ? '0 : ptr_b;
    assign step_a = PTR_W'(num_a);
    assign step_b = PTR_W'(LANES_C - num_a);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_a <= '0;
            ptr_b <= '0;
            seen  <= 1'b0;
        end else begin
            seen <= 1'b1;
            if (req) begin
                ptr_a <= base_a + step_a;
                ptr_b <= base_b + step_b;
            end else if (start) begin
                ptr_a <= '0;
                ptr_b <= '0;
            end
        end
    end

    // R5: the two bases together move by exactly LANES per access
    a_r5_total_advance: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(req) && !$past(start)) |->
            (ptr_a + ptr_b) == ($past(ptr_a) + $past(ptr_b) + PTR_W'(LANES)))
        else $error("bases did not advance by LANES");

    // R6: after start, the bases begin from zero
    a_r6_start_clear: assert property (@(posedge clk) disable iff (rst)
        (seen && $past(start)) |->
            ptr_a == ($past(req) ? PTR_W'($past(num_a)) : '0))
        else $error("start did not clear A base");

    // R8: no request and no start leaves both bases alone
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (seen && !$past(req) && !$past(start)) |->
            ($stable(ptr_a) && $stable(ptr_b)))
        else $error("bases moved without a request");

endmodule

// File: rtl/ilv_addr_gen.sv
module ilv_addr_gen #(
    parameter int LANES  = 8,
    parameter int IDX_W  = 12,
    localparam int CNT_W = ilv_pkg::cnt_width(LANES),
    localparam int PTR_W = IDX_W + 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start,
    input  logic                   req,
    input  logic [LANES-1:0]       sel,
    input  logic [IDX_W-1:0]       len_a,
    input  logic [IDX_W-1:0]       len_b,
    output logic                   out_valid,
    output logic [LANES-1:0]       lane_src,
    output logic [LANES*IDX_W-1:0] lane_idx,
    output logic [LANES-1:0]       lane_past_end,
    output logic [CNT_W-1:0]       out_num_a
);
    import ilv_pkg::*;

    logic [LANES*CNT_W-1:0] acnt;
    logic [CNT_W-1:0]       num_a;
    logic [PTR_W-1:0]       base_a, base_b;
    logic [LANES-1:0]       src_c;
    logic [LANES*IDX_W-1:0] idx_c;
    logic [LANES-1:0]       pe_c;

    ilv_prefix #(.LANES(LANES), .CNT_W(CNT_W)) u_prefix (
        .sel   (sel),
        .acnt  (acnt),
        .num_a (num_a)
    );

    ilv_ptr #(.LANES(LANES), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .req    (req),
        .num_a  (num_a),
        .base_a (base_a),
        .base_b (base_b)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        src_e lsrc;
        ilv_lane #(.IDX_W(IDX_W), .CNT_W(CNT_W), .LANE_ID(i)) u_lane (
            .sel_bit  (sel[i]),
            .acnt     (acnt[i*CNT_W +: CNT_W]),
            .base_a   (base_a),
            .base_b   (base_b),
            .len_a    (len_a),
            .len_b    (len_b),
            .src      (lsrc),
            .idx      (idx_c[i*IDX_W +: IDX_W]),
            .past_end (pe_c[i])
        );
        assign src_c[i] = (lsrc == SRC_A);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid     <= 1'b0;
            lane_src      <= '0;
            lane_idx      <= '0;
            lane_past_end <= '0;
            out_num_a     <= '0;
        end else begin
            out_valid <= req;
            if (req) begin
                lane_src      <= src_c;
                lane_idx      <= idx_c;
                lane_past_end <= pe_c;
                out_num_a     <= num_a;
            end
        end
    end

    // R4: the broadcast total agrees with the per-lane source choices
    a_r4_total_matches: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ($countones(lane_src) == int'(out_num_a)))
        else $error("A total disagrees with lane sources");

    // R2: lane 0 always reads the base of its chosen stream
    a_r2_lane0_base: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> lane_idx[IDX_W-1:0] ==
            (lane_src[0] ? $past(base_a[IDX_W-1:0]) : $past(base_b[IDX_W-1:0])))
        else $error("lane 0 index is not the stream base");

    // R1: nothing valid on the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !out_valid)
        else $error("valid output right after reset");

endmodule

// File: tb/ilv_addr_gen_tb.sv
module ilv_addr_gen_tb;

    localparam int LANES  = 8;
    localparam int IDX_W  = 12;
    localparam int CNT_W  = $clog2(LANES + 1);
    localparam int CLK_NS = 10;

    logic                   clk = 1'b0;
    logic                   rst, start, req;
    logic [LANES-1:0]       sel;
    logic [IDX_W-1:0]       len_a, len_b;
    logic                   out_valid;
    logic [LANES-1:0]       lane_src;
    logic [LANES*IDX_W-1:0] lane_idx;
    logic [LANES-1:0]       lane_past_end;
    logic [CNT_W-1:0]       out_num_a;

    int total = 0;
    int bad   = 0;
    int ma    = 0;   // model A base
    int mb    = 0;   // model B base
    bit done  = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    ilv_addr_gen #(.LANES(LANES), .IDX_W(IDX_W)) u_dut (
        .clk(clk), .rst(rst), .start(start), .req(req), .sel(sel),
        .len_a(len_a), .len_b(len_b), .out_valid(out_valid),
        .lane_src(lane_src), .lane_idx(lane_idx),
        .lane_past_end(lane_past_end), .out_num_a(out_num_a)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    // one access: drive, wait one rising edge, compare against model
    task automatic access(input logic [LANES-1:0] s, input int la, input int lb,
                          input bit with_start, input string rq);
        int acnt, idx, exp_pe, na;
        @(negedge clk);
        sel = s; len_a = IDX_W'(la); len_b = IDX_W'(lb);
        req = 1'b1; start = with_start;
        if (with_start) begin ma = 0; mb = 0; end
        @(negedge clk);
        req = 1'b0; start = 1'b0;
        chk(rq, "out_valid", int'(out_valid), 1);
        acnt = 0;
        for (int i = 0; i < LANES; i++) begin
            if (s[i]) begin
                idx = ma + acnt;               // R2
                exp_pe = (idx >= la) ? 1 : 0;  // R7
            end else begin
                idx = mb + (i - acnt);         // R3
                exp_pe = (idx >= lb) ? 1 : 0;
            end
            chk(rq, $sformatf("src lane %0d", i), int'(lane_src[i]), int'(s[i]));
            chk(rq, $sformatf("idx lane %0d", i), int'(lane_idx[i*IDX_W +: IDX_W]), idx);
            chk(rq, $sformatf("past_end lane %0d", i), int'(lane_past_end[i]), exp_pe);
            if (s[i]) acnt++;
        end
        na = acnt;
        chk(rq, "out_num_a (R4)", int'(out_num_a), na);
        ma += na;                 // R5
        mb += LANES - na;
    endtask

    task automatic t_reset;
        rst = 1'b1; start = 1'b0; req = 1'b0; sel = '0; len_a = '0; len_b = '0;
        repeat (3) @(negedge clk);
        chk("R1", "out_valid in reset", int'(out_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "out_valid after reset", int'(out_valid), 0);
        ma = 0; mb = 0;
    endtask

    task automatic t_mixed;
        access(8'b1010_0110, 4000, 4000, 1'b0, "R1 R2 R3 first access");
        access(8'b0001_1011, 4000, 4000, 1'b0, "R2 R3 R5 mixed");
        access(8'b1000_0001, 4000, 4000, 1'b0, "R2 R3 R5 edges");
    endtask

    task automatic t_uniform;
        access(8'hFF, 4000, 4000, 1'b0, "R9 all A");
        access(8'h00, 4000, 4000, 1'b0, "R9 all B");
    endtask

    task automatic t_idle;
        repeat (3) @(negedge clk);
        chk("R8", "out_valid idle", int'(out_valid), 0);
        access(8'b0110_0101, 4000, 4000, 1'b0, "R8 bases held over idle");
    endtask

    task automatic t_start;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk("R6", "out_valid after lone start", int'(out_valid), 0);
        ma = 0; mb = 0;
        access(8'b1100_0011, 4000, 4000, 1'b0, "R6 after start");
        access(8'b0011_1100, 4000, 4000, 1'b1, "R6 start with request");
        access(8'b0101_0101, 4000, 4000, 1'b0, "R6 advance after start");
    endtask

    task automatic t_past_end;
        // bases here: A=4+4=8? model holds them; lengths placed around them
        access(8'b1111_0000, ma + 2, mb + 3, 1'b0, "R7 boundary");
        access(8'b1010_1010, 0, 0, 1'b0, "R7 empty streams");
    endtask

    initial begin
        #(CLK_NS * 20000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_mixed();
        t_uniform();
        t_idle();
        t_start();
        t_past_end();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule